// File: doc/BRIEF.md
# Memory Controller Debug Trace Mux

This block sits next to a DDR SDRAM controller and exposes, on package pins, which requesting port the controller is serving and when data beats on the memory bus are valid. Each clock it looks at the controller's row-command and column-command strobes, the 5-bit identifier of the request being served, and the data-valid strobe. It registers a trace word made of an ID field and a valid flag. The ID field holds the requester's identifier in command cycles and the all-ones idle code in all other cycles.

The trace word can leave the chip by one of two routes, chosen by a strap input that is latched while reset is held. In pin mode, a dedicated group of five ID pins and one valid pin carries the trace, and the ECC lanes pass the controller's normal check bits through unchanged. In ECC mode, the lower ECC lanes are borrowed for the trace and the upper lanes and the dedicated group are released. A status bit reports which route was latched. All pins are plain control and status signals. There is no handshake and no back-pressure, and the trace is produced every cycle whether or not it is observed.

Top module: `mc_dbg_trace_mux`

## Requirements
- R1: While `rst_n` is low, `strap_i` is sampled on every clock edge. The value from the last edge before release is held in `mode_stat_o`, where 1 means pin mode and 0 means ECC mode.
- R2: After reset is released, changing `strap_i` has no effect on `mode_stat_o` or on the routing of the outputs.
- R3: When `row_cmd_i` or `col_cmd_i` is high at a clock edge, the ID field shows `src_id_i` from that edge, starting one clock later.
- R4: When neither command strobe is high at an edge, the ID field shows 5'h1F one clock later.
- R5: The valid flag equals `data_vld_i` registered by one clock, sampled on the same edge as the command strobes.
- R6: In pin mode, `dbg_id_o` carries the ID field, `dbg_dv_o` carries the valid flag, and `dbg_oe_o` is 1. Also, `ecc_o` equals `ecc_data_i` and every bit of `ecc_oe_o` equals `ecc_oe_i`, with no added delay.
- R7: In ECC mode, `ecc_o[4:0]` carries the ID field (bit 0 = ID bit 0), `ecc_o[5]` carries the valid flag, `ecc_o[7:6]` are 0, `ecc_oe_o` is 8'h3F, and `dbg_oe_o` is 0.
- R8: If both command strobes are high in the same cycle, a single ID is shown: the `src_id_i` presented that cycle. A source ID of 5'h1F is passed through unchanged in a command cycle.
- R9: While in reset and on the first cycle after release, the ID field is 5'h1F and the valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low power-on reset, synchronous |
| strap_i | input | 1 | Route strap: 1 selects pin mode, 0 selects ECC mode |
| row_cmd_i | input | 1 | Row command issued this cycle |
| col_cmd_i | input | 1 | Column command issued this cycle |
| src_id_i | input | 5 | Identifier of the request being served |
| data_vld_i | input | 1 | Valid data beat this cycle |
| ecc_data_i | input | 8 | Normal ECC check bits from the controller |
| ecc_oe_i | input | 1 | Controller's drive enable for the ECC lanes |
| dbg_id_o | output | 5 | Dedicated trace ID pins |
| dbg_dv_o | output | 1 | Dedicated trace valid pin |
| dbg_oe_o | output | 1 | Drive enable for the dedicated trace group |
| ecc_o | output | 8 | ECC lane values |
| ecc_oe_o | output | 8 | Per-lane drive enable for the ECC lanes |
| mode_stat_o | output | 1 | Latched route status bit |

## Verification
The properties assume that the strobes and `src_id_i` are settled at every rising edge and that `strap_i` may move freely, because its value is observed only during reset. The ID and valid checks compare each output with the inputs of the previous edge, and they are disabled in any cycle where reset is low. The bench drives every input on the falling edge, holds reset for several edges, and runs the same stimulus table once under each strap value, so both routes see identical traffic.

// File: rtl/mcdt_pkg.sv
package mcdt_pkg;

  typedef enum logic {
    ROUTE_ECC = 1'b0,
    ROUTE_PIN = 1'b1
  } route_e;

  function automatic logic [4:0] idle_code5();
    return '1;
  endfunction

endpackage

// File: rtl/mcdt_mode_latch.sv
module mcdt_mode_latch
  import mcdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   strap_i,
  output route_e route_o
);

  route_e route_q;

  // The strap is followed on every edge while reset is held, so the value
  // present at the final reset edge is the one kept afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= strap_i ? ROUTE_PIN : ROUTE_ECC;
    end
  end

  assign route_o = route_q;

endmodule

// File: rtl/mcdt_event_reg.sv
module mcdt_event_reg #(
  parameter int ID_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            row_cmd_i,
  input  logic            col_cmd_i,
  input  logic [ID_W-1:0] src_id_i,
  input  logic            data_vld_i,
  output logic [ID_W-1:0] id_o,
  output logic            dv_o
);

  localparam logic [ID_W-1:0] IDLE_ID = '1;

  logic            cmd_any;
  logic [ID_W-1:0] id_d;
  logic [ID_W-1:0] id_q;
  logic            dv_q;

  // One ID per cycle, regardless of whether one or both strobes are set.
  assign cmd_any = row_cmd_i | col_cmd_i;
  assign id_d    = cmd_any ? src_id_i : IDLE_ID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q <= IDLE_ID;
      dv_q <= 1'b0;
    end else begin
      id_q <= id_d;
      dv_q <= data_vld_i;
    end
  end

  assign id_o = id_q;
  assign dv_o = dv_q;

endmodule

// File: rtl/mcdt_pin_router.sv
module mcdt_pin_router
  import mcdt_pkg::*;
#(
  parameter int ID_W  = 5,
  parameter int ECC_W = 8
) (
  input  route_e           route_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             dv_i,
  input  logic [ECC_W-1:0] ecc_data_i,
  input  logic             ecc_oe_i,
  output logic [ID_W-1:0]  dbg_id_o,
  output logic             dbg_dv_o,
  output logic             dbg_oe_o,
  output logic [ECC_W-1:0] ecc_o,
  output logic [ECC_W-1:0] ecc_oe_o
);

  localparam int DV_LANE = ID_W;

  logic pin_mode;
  assign pin_mode = (route_i == ROUTE_PIN);

  assign dbg_id_o = id_i;
  assign dbg_dv_o = dv_i;
  assign dbg_oe_o = pin_mode;

  for (genvar lane = 0; lane < ECC_W; lane++) begin : g_lane
    logic trace_bit;
    logic trace_en;
    if (lane < ID_W) begin : g_id
      assign trace_bit = id_i[lane];
      assign trace_en  = 1'b1;
    end else if (lane == DV_LANE) begin : g_dv
      assign trace_bit = dv_i;
      assign trace_en  = 1'b1;
    end else begin : g_free
      assign trace_bit = 1'b0;
      assign trace_en  = 1'b0;
    end
    assign ecc_o[lane]    = pin_mode ? ecc_data_i[lane] : trace_bit;
    assign ecc_oe_o[lane] = pin_mode ? ecc_oe_i : trace_en;
  end

endmodule

// File: rtl/mc_dbg_trace_mux.sv
module mc_dbg_trace_mux
  import mcdt_pkg::*;
#(
  parameter int ID_W  = 5,
  parameter int ECC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_i,
  input  logic             row_cmd_i,
  input  logic             col_cmd_i,
  input  logic [ID_W-1:0]  src_id_i,
  input  logic             data_vld_i,
  input  logic [ECC_W-1:0] ecc_data_i,
  input  logic             ecc_oe_i,
  output logic [ID_W-1:0]  dbg_id_o,
  output logic             dbg_dv_o,
  output logic             dbg_oe_o,
  output logic [ECC_W-1:0] ecc_o,
  output logic [ECC_W-1:0] ecc_oe_o,
  output logic             mode_stat_o
);

  route_e          route;
  logic [ID_W-1:0] trace_id;
  logic            trace_dv;

  mcdt_mode_latch u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_i),
    .route_o (route)
  );

  mcdt_event_reg #(.ID_W(ID_W)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_cmd_i  (row_cmd_i),
    .col_cmd_i  (col_cmd_i),
    .src_id_i   (src_id_i),
    .data_vld_i (data_vld_i),
    .id_o       (trace_id),
    .dv_o       (trace_dv)
  );

  mcdt_pin_router #(.ID_W(ID_W), .ECC_W(ECC_W)) u_route (
    .route_i    (route),
    .id_i       (trace_id),
    .dv_i       (trace_dv),
    .ecc_data_i (ecc_data_i),
    .ecc_oe_i   (ecc_oe_i),
    .dbg_id_o   (dbg_id_o),
    .dbg_dv_o   (dbg_dv_o),
    .dbg_oe_o   (dbg_oe_o),
    .ecc_o      (ecc_o),
    .ecc_oe_o   (ecc_oe_o)
  );

  assign mode_stat_o = (route == ROUTE_PIN);

endmodule

// File: rtl/mcdt_chk.sv
module mcdt_chk #(
  parameter int ID_W  = 5,
  parameter int ECC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_cmd_i,
  input logic             col_cmd_i,
  input logic [ID_W-1:0]  src_id_i,
  input logic             data_vld_i,
  input logic [ECC_W-1:0] ecc_data_i,
  input logic             ecc_oe_i,
  input logic [ID_W-1:0]  dbg_id_o,
  input logic             dbg_dv_o,
  input logic             dbg_oe_o,
  input logic [ECC_W-1:0] ecc_o,
  input logic [ECC_W-1:0] ecc_oe_o,
  input logic             mode_stat_o
);

  logic [ID_W-1:0] seen_id;
  logic            seen_dv;
  assign seen_id = mode_stat_o ? dbg_id_o : ecc_o[ID_W-1:0];
  assign seen_dv = mode_stat_o ? dbg_dv_o : ecc_o[ID_W];

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_stat_o));

  // R3
  cmd_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_cmd_i || col_cmd_i) |=> (seen_id == $past(src_id_i)));

  // R4
  idle_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_cmd_i && !col_cmd_i) |=> (seen_id == '1));

  // R5
  dv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_i |=> seen_dv);

  // R5
  dv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_vld_i |=> !seen_dv);

  // R6
  pin_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat_o |-> (dbg_oe_o && ecc_o == ecc_data_i && ecc_oe_o == {ECC_W{ecc_oe_i}}));

  // R7
  ecc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_stat_o |-> (!dbg_oe_o && $countones(ecc_oe_o) == ID_W + 1 && ecc_oe_o[ID_W:0] == '1));

endmodule

bind mc_dbg_trace_mux mcdt_chk #(.ID_W(ID_W), .ECC_W(ECC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .row_cmd_i   (row_cmd_i),
  .col_cmd_i   (col_cmd_i),
  .src_id_i    (src_id_i),
  .data_vld_i  (data_vld_i),
  .ecc_data_i  (ecc_data_i),
  .ecc_oe_i    (ecc_oe_i),
  .dbg_id_o    (dbg_id_o),
  .dbg_dv_o    (dbg_dv_o),
  .dbg_oe_o    (dbg_oe_o),
  .ecc_o       (ecc_o),
  .ecc_oe_o    (ecc_oe_o),
  .mode_stat_o (mode_stat_o)
);

// File: tb/mc_dbg_trace_mux_tb.sv
`timescale 1ns/1ps
module mc_dbg_trace_mux_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_i = 1'b1;
  logic       row_cmd_i = 1'b0;
  logic       col_cmd_i = 1'b0;
  logic [4:0] src_id_i = 5'h00;
  logic       data_vld_i = 1'b0;
  logic [7:0] ecc_data_i = 8'h00;
  logic       ecc_oe_i = 1'b0;
  logic [4:0] dbg_id_o;
  logic       dbg_dv_o;
  logic       dbg_oe_o;
  logic [7:0] ecc_o;
  logic [7:0] ecc_oe_o;
  logic       mode_stat_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mc_dbg_trace_mux u_dut (
    .clk (clk), .rst_n (rst_n), .strap_i (strap_i),
    .row_cmd_i (row_cmd_i), .col_cmd_i (col_cmd_i), .src_id_i (src_id_i),
    .data_vld_i (data_vld_i), .ecc_data_i (ecc_data_i), .ecc_oe_i (ecc_oe_i),
    .dbg_id_o (dbg_id_o), .dbg_dv_o (dbg_dv_o), .dbg_oe_o (dbg_oe_o),
    .ecc_o (ecc_o), .ecc_oe_o (ecc_oe_o), .mode_stat_o (mode_stat_o)
  );

  // {row, col, src[4:0], dv, expected id[4:0], expected dv}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 1'b0, 5'h0F, 1'b0, 5'h0F, 1'b0},
    {1'b0, 1'b1, 5'h0C, 1'b1, 5'h0C, 1'b1},
    {1'b0, 1'b0, 5'h0D, 1'b1, 5'h1F, 1'b1},
    {1'b1, 1'b1, 5'h0A, 1'b0, 5'h0A, 1'b0},
    {1'b1, 1'b0, 5'h1F, 1'b1, 5'h1F, 1'b1},
    {1'b0, 1'b0, 5'h18, 1'b0, 5'h1F, 1'b0},
    {1'b0, 1'b1, 5'h18, 1'b0, 5'h18, 1'b0},
    {1'b1, 1'b0, 5'h00, 1'b1, 5'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_i = ~strap;
    row_cmd_i = 1'b1; col_cmd_i = 1'b0; src_id_i = 5'h05; data_vld_i = 1'b1;
    repeat (2) @(negedge clk);
    strap_i = strap;
    repeat (2) @(negedge clk);
    row_cmd_i = 1'b0; data_vld_i = 1'b0;
    rst_n = 1'b1;
    #1;
  endtask

  function automatic logic [4:0] obs_id();
    return mode_stat_o ? dbg_id_o : ecc_o[4:0];
  endfunction

  function automatic logic obs_dv();
    return mode_stat_o ? dbg_dv_o : ecc_o[5];
  endfunction

  task automatic run_table(input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {row_cmd_i, col_cmd_i, src_id_i, data_vld_i} = VEC[i][13:6];
      @(posedge clk);
      #1;
      if (VEC[i][13] || VEC[i][12]) begin
        chk({"R3/R8 id ", tag}, obs_id(), VEC[i][5:1]);
      end else begin
        chk({"R4 idle id ", tag}, obs_id(), VEC[i][5:1]);
      end
      chk({"R5 valid ", tag}, obs_dv(), VEC[i][0]);
    end
    @(negedge clk);
    row_cmd_i = 1'b0; col_cmd_i = 1'b0; data_vld_i = 1'b0;
  endtask

  initial begin
    // pin mode
    do_reset(1'b1);
    chk("R1 mode latched pin", mode_stat_o, 1);
    chk("R9 reset id", dbg_id_o, 5'h1F);
    chk("R9 reset dv", dbg_dv_o, 0);
    ecc_data_i = 8'hA5; ecc_oe_i = 1'b1;
    #1;
    chk("R6 dbg_oe", dbg_oe_o, 1);
    chk("R6 ecc pass", ecc_o, 8'hA5);
    chk("R6 ecc oe", ecc_oe_o, 8'hFF);
    ecc_data_i = 8'h3C; ecc_oe_i = 1'b0;
    #1;
    chk("R6 ecc pass 2", ecc_o, 8'h3C);
    chk("R6 ecc oe 2", ecc_oe_o, 8'h00);
    run_table("pin");
    // strap toggled after reset
    strap_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 mode held", mode_stat_o, 1);
    chk("R2 dbg_oe held", dbg_oe_o, 1);

    // ECC mode
    do_reset(1'b0);
    chk("R1 mode latched ecc", mode_stat_o, 0);
    chk("R9 reset id ecc", ecc_o[4:0], 5'h1F);
    chk("R9 reset dv ecc", ecc_o[5], 0);
    ecc_data_i = 8'hFF; ecc_oe_i = 1'b1;
    #1;
    chk("R7 ecc oe", ecc_oe_o, 8'h3F);
    chk("R7 dbg_oe", dbg_oe_o, 0);
    chk("R7 upper lanes", ecc_o[7:6], 0);
    run_table("ecc");
    strap_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 mode held ecc", mode_stat_o, 0);
    chk("R2 ecc oe held", ecc_oe_o, 8'h3F);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule